// File: doc/BRIEF.md
# Per-Symbol Weighted Minor Accumulator

This block serves a step-by-step Reed-Solomon decoder over GF(2^8). For each symbol position j of a 255-symbol codeword it produces two field sums. The first is H(v,j), the XOR over x=1..v of α^((2x−1)·j)·D_x. The second, H(v+1,j), uses the same form with one more term and a separate set of minor determinants. The minors are computed upstream. The division that turns these sums into an error value happens downstream.

At the start of a codeword, a load strobe captures both minor sets and the detected error count v. From then on, each advance strobe moves to the next symbol position. Every term register is multiplied by its own fixed power of α, so no per-symbol exponentiation is needed. A selector then picks the partial XOR sum whose length matches v. The outputs are combinational from the term registers and carry a valid flag together with the current position. After position 254 the block stops and raises a codeword-complete flag.

Top module: `wdet_accum`

## Requirements
- R1: While reset is held, and after it is released, valid_o and done_o are 0, pos_o is 0, and both sums are 0 until the first load.
- R2: On the clock edge that samples load_i high, the block sets valid_o to 1, pos_o to 0 and done_o to 0. From that edge on, h_v_o equals the XOR of minors D_1..D_v and h_v1_o equals the XOR of E_1..E_(v+1). Here D_x sits in minor_v_i[8x-1:8x-8] and E_x sits in minor_v1_i[8x-1:8x-8].
- R3: Each advance (adv_i high, load_i low, valid_o high, pos_o below 254) raises pos_o by one. After it, h_v_o equals the sum over x=1..v of α^((2x−1)·j)·D_x and h_v1_o equals the sum over x=1..v+1 of α^((2x−1)·j)·E_x, where j=pos_o. The field is GF(2^8) with polynomial x^8+x^4+x^3+x^2+1 and α=0x02.
- R4: In a cycle with neither strobe, pos_o and both sums hold their values.
- R5: Minors with index above v (for h_v_o), or above v+1 (for h_v1_o), have no effect on the outputs.
- R6: A loaded count of 0 gives zero on both sums at every position. A count above 8 acts as 8.
- R7: An advance at position 254 clears valid_o and sets done_o. Later advances leave pos_o at 254 and done_o at 1.
- R8: A load while a codeword is in progress restarts at position 0 with the new minors and count.
- R9: Whenever valid_o is 0, both sums read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Capture minors and error count; start at position 0 |
| adv_i | input | 1 | Advance to the next symbol position |
| err_cnt_i | input | 4 | Detected error count v |
| minor_v_i | input | 64 | Minors D_1..D_8, 8 bits each, D_1 in the low byte |
| minor_v1_i | input | 72 | Minors E_1..E_9, 8 bits each, E_1 in the low byte |
| h_v_o | output | 8 | H(v,j) for the current position |
| h_v1_o | output | 8 | H(v+1,j) for the current position |
| valid_o | output | 1 | Sums are valid for pos_o |
| pos_o | output | 8 | Current symbol position j |
| done_o | output | 1 | Codeword complete |

## Verification
Several patterns exercise the sums. A full 255-position walk with v=8 uses distinct minors, so every term constant must be right at every position; a wrong α power or a wrong polynomial would show up within a few steps. A short load with v=3 checks the plain j=0 sum. A pair of loads that differ only in minors above the active count separates a correct selector from one that takes too many terms. Counts of 0 and 12, plus a reload in the middle of a walk, separate the zero forcing, the saturation and the restart paths from the normal advance.

// File: rtl/wdet_pkg.sv
package wdet_pkg;
  localparam int unsigned GF_W = 8;
  localparam logic [GF_W-1:0] GF_REDUCE = 8'h1D; // x^8 = x^4+x^3+x^2+1

  function automatic logic [GF_W-1:0] gf_mul(input logic [GF_W-1:0] a,
                                             input logic [GF_W-1:0] b);
    logic [GF_W-1:0] acc;
    logic [GF_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[GF_W-1] ? ({sh[GF_W-2:0], 1'b0} ^ GF_REDUCE) : {sh[GF_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic logic [GF_W-1:0] alpha_pow(input int e);
    logic [GF_W-1:0] p;
    p = 8'h01;
    for (int i = 0; i < e; i++) p = gf_mul(p, 8'h02);
    return p;
  endfunction
endpackage

// File: rtl/wdet_const_mul.sv
module wdet_const_mul #(
  parameter logic [7:0] K = 8'h02
) (
  input  logic [7:0] a_i,
  output logic [7:0] p_o
);
  // K is fixed at elaboration, so this reduces to an XOR network.
  assign p_o = wdet_pkg::gf_mul(a_i, K);
endmodule

// File: rtl/wdet_term_bank.sv
module wdet_term_bank #(
  parameter int unsigned NT = 8,
  parameter int unsigned W  = 8,
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [NT*W-1:0] minors_i,
  input  logic [SW-1:0] sel_i,
  output logic [W-1:0]  sum_o
);
  logic [W-1:0] term_q  [NT];
  logic [W-1:0] term_d  [NT];
  logic [W-1:0] stepped [NT];
  logic [W-1:0] psum    [NT+1];
  logic         term_en;

  assign term_en = load_i | step_i;
  assign psum[0] = '0;

  for (genvar g = 0; g < NT; g++) begin : g_term
    localparam logic [7:0] KG = wdet_pkg::alpha_pow(2 * g + 1);

    wdet_const_mul #(.K(KG)) u_cmul (
      .a_i(term_q[g]),
      .p_o(stepped[g])
    );

    always_comb begin
      term_d[g] = load_i ? minors_i[g*W +: W] : stepped[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       term_q[g] <= '0;
      else if (term_en) term_q[g] <= term_d[g];
    end

    assign psum[g+1] = psum[g] ^ term_q[g];
  end

  // (NT+1)-way selector over the prefix sums.
  always_comb begin
    sum_o = psum[NT];
    for (int k = 0; k <= NT; k++) begin
      if (sel_i == SW'(k)) sum_o = psum[k];
    end
  end
endmodule

// File: rtl/wdet_accum.sv
module wdet_accum #(
  parameter int unsigned MAX_ERR  = 8,
  parameter int unsigned CODE_LEN = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [3:0]   err_cnt_i,
  input  logic [63:0]  minor_v_i,
  input  logic [71:0]  minor_v1_i,
  output logic [7:0]   h_v_o,
  output logic [7:0]   h_v1_o,
  output logic         valid_o,
  output logic [7:0]   pos_o,
  output logic         done_o
);
  localparam int unsigned W     = wdet_pkg::GF_W;
  localparam int unsigned CW    = $clog2(MAX_ERR + 2);
  localparam int unsigned POS_W = $clog2(CODE_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CODE_LEN - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic             active_q, active_d;
  logic             done_q, done_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    cnt_sat;
  logic             step, term_step;
  logic [CW-1:0]    sel_a, sel_b;
  logic [W-1:0]     sum_a, sum_b;

  assign cnt_sat   = (err_cnt_i > CW'(MAX_ERR)) ? CW'(MAX_ERR) : err_cnt_i;
  assign step      = active_q & adv_i & ~load_i;
  assign term_step = step & (pos_q != LAST_POS);

  always_comb begin
    active_d = active_q;
    done_d   = done_q;
    pos_d    = pos_q;
    cnt_d    = cnt_q;
    if (load_i) begin
      active_d = 1'b1;
      done_d   = 1'b0;
      pos_d    = '0;
      cnt_d    = cnt_sat;
    end else if (step) begin
      if (pos_q == LAST_POS) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      pos_q    <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      pos_q    <= pos_d;
      cnt_q    <= cnt_d;
    end
  end

  assign sel_a = cnt_q;
  assign sel_b = (cnt_q == '0) ? '0 : cnt_q + 1'b1;

  wdet_term_bank #(.NT(MAX_ERR), .W(W), .SW(CW)) u_bank_v (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load_i), .step_i(term_step),
    .minors_i(minor_v_i), .sel_i(sel_a), .sum_o(sum_a)
  );

  wdet_term_bank #(.NT(MAX_ERR + 1), .W(W), .SW(CW)) u_bank_v1 (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load_i), .step_i(term_step),
    .minors_i(minor_v1_i), .sel_i(sel_b), .sum_o(sum_b)
  );

  assign h_v_o   = active_q ? sum_a : '0;
  assign h_v1_o  = active_q ? sum_b : '0;
  assign valid_o = active_q;
  assign pos_o   = pos_q;
  assign done_o  = done_q;
endmodule

// File: rtl/wdet_accum_chk.sv
module wdet_accum_chk #(
  parameter logic [7:0] LAST_POS = 8'd254
) (
  input logic       clk,
  input logic       rst_n,
  input logic       load_i,
  input logic       adv_i,
  input logic [3:0] err_cnt_i,
  input logic [7:0] h_v_o,
  input logic [7:0] h_v1_o,
  input logic       valid_o,
  input logic [7:0] pos_o,
  input logic       done_o
);
  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (valid_o && !done_o && pos_o == 8'd0));

  assert_pos_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && adv_i && !load_i && pos_o != LAST_POS) |=> (pos_o == $past(pos_o) + 8'd1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !adv_i && !load_i) |=> ($stable(pos_o) && $stable(h_v_o) && $stable(h_v1_o)));

  assert_vzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && err_cnt_i == 4'd0) |=> (h_v_o == 8'd0 && h_v1_o == 8'd0));

  assert_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && adv_i && !load_i && pos_o == LAST_POS) |=> (done_o && !valid_o));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && done_o));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (h_v_o == 8'd0 && h_v1_o == 8'd0));
endmodule

bind wdet_accum wdet_accum_chk #(.LAST_POS(LAST_POS)) u_wdet_chk (
  .clk(clk), .rst_n(rst_sync_n), .load_i(load_i), .adv_i(adv_i),
  .err_cnt_i(err_cnt_i), .h_v_o(h_v_o), .h_v1_o(h_v1_o),
  .valid_o(valid_o), .pos_o(pos_o), .done_o(done_o)
);

// File: tb/tb_wdet_accum.sv
module tb_wdet_accum;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i, adv_i;
  logic [3:0]  err_cnt_i;
  logic [63:0] minor_v_i;
  logic [71:0] minor_v1_i;
  logic [7:0]  h_v_o, h_v1_o, pos_o;
  logic        valid_o, done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  wdet_accum dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .err_cnt_i(err_cnt_i), .minor_v_i(minor_v_i), .minor_v1_i(minor_v1_i),
    .h_v_o(h_v_o), .h_v1_o(h_v1_o), .valid_o(valid_o), .pos_o(pos_o),
    .done_o(done_o)
  );

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= s;
      s = s[7] ? ((s << 1) ^ 8'h1D) : (s << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_sum(input logic [71:0] m, input int n, input int j);
    logic [7:0] acc = 8'h00;
    for (int x = 1; x <= n; x++) begin
      logic [7:0] p = 8'h01;
      int e = ((2 * x - 1) * j) % 255;
      for (int k = 0; k < e; k++) p = fmul(p, 8'h02);
      acc ^= fmul(m[8*(x-1) +: 8], p);
    end
    return acc;
  endfunction

  function automatic int nterms_a(input int v);
    return (v > 8) ? 8 : v;
  endfunction
  function automatic int nterms_b(input int v);
    return (v == 0) ? 0 : nterms_a(v) + 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input int v, input logic [63:0] ma, input logic [71:0] mb);
    err_cnt_i = 4'(v); minor_v_i = ma; minor_v1_i = mb; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_adv();
    adv_i = 1'b1;
    @(negedge clk);
    adv_i = 1'b0;
  endtask

  task automatic chk_sums(input string tag, input int v, input int j,
                          input logic [63:0] ma, input logic [71:0] mb);
    chk({tag, " h_v"},  h_v_o,  ref_sum({8'h00, ma}, nterms_a(v), j));
    chk({tag, " h_v1"}, h_v1_o, ref_sum(mb, nterms_b(v), j));
    chk({tag, " pos"},  pos_o,  j);
    chk({tag, " valid"}, valid_o, 1);
  endtask

  localparam logic [63:0] MA = 64'h9C_41_E7_0B_5A_D3_26_8F;
  localparam logic [71:0] MB = 72'h71_B8_03_EE_4D_92_15_6A_C7;

  task automatic t_reset();
    rst_n = 1'b0; load_i = 1'b0; adv_i = 1'b0;
    err_cnt_i = '0; minor_v_i = '0; minor_v1_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 done in reset", done_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pos after reset", pos_o, 0);
    chk("R1 h_v after reset", h_v_o, 0);
    chk("R1 h_v1 after reset", h_v1_o, 0);
    chk("R1 valid after reset", valid_o, 0);
  endtask

  task automatic t_load_sum();
    do_load(3, MA, MB);
    chk_sums("R2 j0 v3", 3, 0, MA, MB);
    chk("R2 done clear", done_o, 0);
  endtask

  task automatic t_walk();
    do_load(8, MA, MB);
    chk_sums("R2 j0 v8", 8, 0, MA, MB);
    for (int j = 1; j <= 254; j++) begin
      do_adv();
      chk_sums("R3 walk v8", 8, j, MA, MB);
    end
  endtask

  task automatic t_hold();
    do_load(5, MA, MB);
    repeat (3) do_adv();
    repeat (4) @(negedge clk);
    chk_sums("R4 hold", 5, 3, MA, MB);
  endtask

  task automatic t_select();
    logic [63:0] ma2;
    logic [71:0] mb2;
    ma2 = {MA[63:16] ^ 48'hFFFF_FFFF_FFFF, MA[15:0]};
    mb2 = {MB[71:24] ^ 48'h5555_AAAA_5555, MB[23:0]};
    do_load(2, ma2, mb2);
    chk_sums("R5 upper minors ignored", 2, 0, MA, MB);
    repeat (7) do_adv();
    chk_sums("R5 upper minors ignored", 2, 7, MA, MB);
  endtask

  task automatic t_count_edges();
    do_load(0, MA, MB);
    chk("R6 v0 h_v", h_v_o, 0);
    chk("R6 v0 h_v1", h_v1_o, 0);
    do_adv();
    chk("R6 v0 h_v j1", h_v_o, 0);
    chk("R6 v0 h_v1 j1", h_v1_o, 0);
    do_load(12, MA, MB);
    repeat (5) do_adv();
    chk_sums("R6 v12 as v8", 8, 5, MA, MB);
  endtask

  task automatic t_restart();
    do_load(4, MA, MB);
    repeat (10) do_adv();
    do_load(6, ~MA, ~MB);
    chk_sums("R8 restart", 6, 0, ~MA, ~MB);
    do_adv();
    chk_sums("R8 restart", 6, 1, ~MA, ~MB);
  endtask

  task automatic t_end();
    do_load(7, MA, MB);
    repeat (254) do_adv();
    chk_sums("R3 last pos", 7, 254, MA, MB);
    do_adv();
    chk("R7 done", done_o, 1);
    chk("R7 valid", valid_o, 0);
    chk("R9 h_v idle", h_v_o, 0);
    chk("R9 h_v1 idle", h_v1_o, 0);
    do_adv();
    do_adv();
    chk("R7 pos frozen", pos_o, 254);
    chk("R7 done kept", done_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_load_sum();
    t_walk();
    t_hold();
    t_select();
    t_count_edges();
    t_restart();
    t_end();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule